// File: doc/BRIEF.md
# Strided Interleave Quadword DMA Engine

This engine copies a block of 128-bit quadwords between a main-memory port and a scratchpad port. The copy is cut into bursts of a programmed length. After each burst, the main-memory address jumps over a programmed number of quadwords, while the scratchpad address stays dense. This lets a strided region in main memory be packed into a dense scratchpad buffer, or a dense buffer be scattered back out. A burst length of zero means one burst that covers the whole count. In that case no gap is ever inserted.

Software places the count, both base addresses, the burst length, the skip count and the direction on the inputs, then pulses `start`. The engine latches all of these on that pulse. It reads one quadword per beat from the source side into a one-entry holding register, then writes it to the destination side. Each beat uses a valid/ready handshake, so either port can stall the engine. When the last write beat is accepted, `busy` falls and `done` pulses for one cycle.

Top module: `qw_stride_dma`

## Requirements
- R1: After reset, `busy`, `done`, `rd_valid` and `wr_valid` are 0 and `qw_left` is 0.
- R2: A `start` pulse is accepted only while `busy` is 0. A pulse while busy changes neither the running address sequence, the count nor the configuration, and no new transfer follows it. While idle, `rd_valid` and `wr_valid` stay 0.
- R3: When `dir`=0, reads use main-memory addresses and writes use scratchpad addresses. When `dir`=1, reads use scratchpad addresses and writes use main-memory addresses.
- R4: The scratchpad address of the k-th quadword (k from 0) is `spad_base + 16*k`.
- R5: With effective burst length B, the main-memory address of the k-th quadword is `mem_base + 16*(k + skip_qw*floor(k/B))`. The gap follows every full burst, on the main-memory side only.
- R6: `burst_qw`=0 gives B equal to `total_qw`, so the main-memory side is one contiguous run with no gap.
- R7: Each burst moves min(B, quadwords still to move). A final short burst ends the transfer, and no read beyond `total_qw` quadwords is issued.
- R8: The k-th write carries the data returned by the k-th read.
- R9: While `rd_valid` or `wr_valid` is high and its ready is low, the valid stays high and the address (and, for writes, the data) stays unchanged on the next cycle.
- R10: `done` is high for exactly one cycle: the cycle after the last write handshake. In that cycle `busy` is 0 and `qw_left` is 0.
- R11: A start with `total_qw`=0 moves no data and gives a `done` pulse in the cycle after the start.
- R12: `qw_left` equals `total_qw` minus the number of accepted write beats. It drops by one on each write handshake and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, sampled while idle |
| dir | input | 1 | 0: memory to scratchpad, 1: scratchpad to memory |
| total_qw | input | CW | Quadwords to move |
| mem_base | input | AW | Main-memory byte start address |
| spad_base | input | AW | Scratchpad byte start address |
| burst_qw | input | CW | Quadwords per burst, 0 = whole count |
| skip_qw | input | CW | Quadwords skipped on main memory after each burst |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read accepted; data on `rd_data` in the same cycle |
| rd_addr | output | AW | Read byte address |
| rd_data | input | DW | Read quadword |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | AW | Write byte address |
| wr_data | output | DW | Write quadword |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| qw_left | output | CW | Quadwords not yet written |

## Verification
The hardest case to reach is a burst boundary that lines up with back-pressure. Here the read side has already stepped over the gap while the write side is still stalled on the last beat of the earlier burst, so the two address counters sit in different bursts. Random ready patterns on both ports, combined with random burst and skip lengths that often do not divide the count, produce this offset many times per run. Directed cases add a zero burst length, a burst longer than the count, a zero count and a start pulse arriving mid-transfer.

// File: rtl/qw_stride_dma.sv
module qw_stride_dma #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir,
  input  logic [CW-1:0] total_qw,
  input  logic [AW-1:0] mem_base,
  input  logic [AW-1:0] spad_base,
  input  logic [CW-1:0] burst_qw,
  input  logic [CW-1:0] skip_qw,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] qw_left
);
  localparam int QB = DW / 8;
  localparam int SH = $clog2(QB);

  logic          busy_q, done_q, dir_q, full_q;
  logic [CW-1:0] rd_left, wr_left, burst_q, skip_q, rd_cnt, wr_cnt;
  logic [AW-1:0] rd_addr_q, wr_addr_q;
  logic [DW-1:0] buf_q;
  logic          rd_fire, wr_fire;

  function automatic logic [AW-1:0] next_addr(logic [AW-1:0] a, logic [CW-1:0] c, logic mem_side);
    logic [AW-1:0] n;
    n = a + AW'(QB);
    if (mem_side && c == burst_q - 1'b1)
      n = n + (AW'(skip_q) << SH);
    return n;
  endfunction

  function automatic logic [CW-1:0] next_cnt(logic [CW-1:0] c);
    return (c == burst_q - 1'b1) ? '0 : c + 1'b1;
  endfunction

  assign rd_valid = busy_q && !full_q && rd_left != '0;
  assign wr_valid = full_q;
  assign rd_addr  = rd_addr_q;
  assign wr_addr  = wr_addr_q;
  assign wr_data  = buf_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign qw_left  = wr_left;
  assign rd_fire  = rd_valid && rd_ready;
  assign wr_fire  = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      dir_q     <= 1'b0;
      full_q    <= 1'b0;
      rd_left   <= '0;
      wr_left   <= '0;
      burst_q   <= '0;
      skip_q    <= '0;
      rd_cnt    <= '0;
      wr_cnt    <= '0;
      rd_addr_q <= '0;
      wr_addr_q <= '0;
      buf_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          if (total_qw == '0) begin
            done_q <= 1'b1;
          end else begin
            busy_q    <= 1'b1;
            dir_q     <= dir;
            burst_q   <= (burst_qw == '0) ? total_qw : burst_qw;
            skip_q    <= skip_qw;
            rd_left   <= total_qw;
            wr_left   <= total_qw;
            rd_cnt    <= '0;
            wr_cnt    <= '0;
            full_q    <= 1'b0;
            rd_addr_q <= dir ? spad_base : mem_base;
            wr_addr_q <= dir ? mem_base : spad_base;
          end
        end
      end else begin
        if (rd_fire) begin
          buf_q     <= rd_data;
          rd_left   <= rd_left - 1'b1;
          rd_addr_q <= next_addr(rd_addr_q, rd_cnt, !dir_q);
          rd_cnt    <= next_cnt(rd_cnt);
        end
        if (wr_fire) begin
          wr_left   <= wr_left - 1'b1;
          wr_addr_q <= next_addr(wr_addr_q, wr_cnt, dir_q);
          wr_cnt    <= next_cnt(wr_cnt);
          if (wr_left == CW'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
        full_q <= rd_fire || (full_q && !wr_fire);
      end
    end
  end
endmodule

// File: rtl/qw_stride_dma_chk.sv
module qw_stride_dma_chk #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          dir,
  input logic [CW-1:0] total_qw,
  input logic [AW-1:0] mem_base,
  input logic [AW-1:0] spad_base,
  input logic [CW-1:0] burst_qw,
  input logic [CW-1:0] skip_qw,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic [DW-1:0] rd_data,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] qw_left
);
  localparam int QB = DW / 8;

  logic          dir_l, have_rd, have_wr;
  logic [AW-1:0] prev_rd, prev_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_l   <= 1'b0;
      have_rd <= 1'b0;
      have_wr <= 1'b0;
      prev_rd <= '0;
      prev_wr <= '0;
    end else if (start && !busy) begin
      dir_l   <= dir;
      have_rd <= 1'b0;
      have_wr <= 1'b0;
    end else begin
      if (rd_valid && rd_ready) begin
        have_rd <= 1'b1;
        prev_rd <= rd_addr;
      end
      if (wr_valid && wr_ready) begin
        have_wr <= 1'b1;
        prev_wr <= wr_addr;
      end
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> !busy && !done && !rd_valid && !wr_valid && qw_left == '0);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_valid && !wr_valid);

  p_spad_dense_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !dir_l && have_wr) |-> wr_addr == prev_wr + AW'(QB));

  p_spad_dense_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && dir_l && have_rd) |-> rd_addr == prev_rd + AW'(QB));

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid && $stable(rd_addr));

  p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && qw_left == '0);

  p_left_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_valid && wr_ready) |=> qw_left == $past(qw_left) - 1'b1);

  p_left_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(wr_valid && wr_ready)) |=> qw_left == $past(qw_left));
endmodule

bind qw_stride_dma qw_stride_dma_chk #(.AW(AW), .CW(CW), .DW(DW)) u_chk (.*);

// File: tb/qw_stride_dma_tb.sv
module qw_stride_dma_tb;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int DW = 128;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          dir = 1'b0;
  logic [CW-1:0] total_qw = '0;
  logic [AW-1:0] mem_base = '0;
  logic [AW-1:0] spad_base = '0;
  logic [CW-1:0] burst_qw = '0;
  logic [CW-1:0] skip_qw = '0;
  logic          rd_valid, rd_ready = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          wr_valid, wr_ready = 1'b0;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          busy, done;
  logic [CW-1:0] qw_left;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] pat(logic [AW-1:0] a);
    return {a ^ 32'hA5A5_0000, ~a, a * 32'd3, a + 32'h1234};
  endfunction

  assign rd_data = pat(rd_addr);

  qw_stride_dma #(.AW(AW), .CW(CW), .DW(DW)) u_dut (.*);

  task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mem_at(logic [AW-1:0] base, int k, int b, int sk);
    return base + AW'(16 * (k + sk * (k / b)));
  endfunction

  task automatic run_xfer(bit d, int tot, logic [AW-1:0] mb, logic [AW-1:0] sb,
                          int bl, int sk, bit rnd_ready, int mid);
    int k_rd = 0;
    int k_wr = 0;
    int guard = 0;
    bit fin = 0;
    int b = (bl == 0) ? tot : bl;
    string mtag = (bl == 0) ? "R6" : ((tot % bl) != 0 ? "R5 R7" : "R5");
    logic [AW-1:0] src, dst;
    @(negedge clk);
    dir = d; total_qw = CW'(tot); mem_base = mb; spad_base = sb;
    burst_qw = CW'(bl); skip_qw = CW'(sk); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (tot == 0) begin
      rd_ready = 1'b1; wr_ready = 1'b1;
      #1;
      chk(done && !busy, "R11", "done after empty start", {busy, done}, 2'b01);
      chk(!rd_valid && !wr_valid, "R11", "no beats on empty start", {rd_valid, wr_valid}, 0);
      @(negedge clk);
      chk(!done, "R10", "done single cycle", done, 0);
      return;
    end
    while (!fin && guard < 5000) begin
      rd_ready = rnd_ready ? ($urandom % 3 != 0) : 1'b1;
      wr_ready = rnd_ready ? ($urandom % 3 != 0) : 1'b1;
      if (guard == mid && k_wr + 1 < tot) begin
        start = 1'b1; dir = ~d; total_qw = CW'($urandom % 7 + 1);
        mem_base = $urandom; spad_base = $urandom; burst_qw = CW'(1); skip_qw = CW'(3);
      end else begin
        start = 1'b0;
      end
      #1;
      if (rd_valid) begin
        if (k_rd >= tot) begin
          chk(0, "R7", "read beyond count", k_rd, tot);
        end else begin
          src = d ? sb + AW'(16 * k_rd) : mem_at(mb, k_rd, b, sk);
          chk(rd_addr == src, d ? "R3 R4" : {"R3 ", mtag}, "read address", rd_addr, src);
          if (mid >= 0) chk(rd_addr == src, "R2", "read address after busy start", rd_addr, src);
          if (rd_ready) k_rd++;
        end
      end
      if (wr_valid) begin
        src = d ? sb + AW'(16 * k_wr) : mem_at(mb, k_wr, b, sk);
        dst = d ? mem_at(mb, k_wr, b, sk) : sb + AW'(16 * k_wr);
        chk(qw_left == CW'(tot - k_wr), "R12", "remaining count", qw_left, tot - k_wr);
        chk(wr_addr == dst, d ? {"R3 ", mtag} : "R3 R4", "write address", wr_addr, dst);
        chk(wr_data == pat(src), "R8", "write data", wr_data, pat(src));
        if (!wr_ready) chk(busy && !done, "R9", "held write keeps engine busy", {busy, done}, 2'b10);
        if (wr_ready) begin
          k_wr++;
          if (k_wr == tot) fin = 1;
        end
      end
      @(negedge clk);
      guard++;
    end
    start = 1'b0; rd_ready = 1'b0; wr_ready = 1'b0;
    #1;
    chk(fin, "R7", "all beats written", k_wr, tot);
    chk(done && !busy, "R10", "done after last write", {busy, done}, 2'b01);
    chk(qw_left == '0, "R10", "count zero at done", qw_left, 0);
    @(negedge clk);
    chk(!done, "R10", "done single cycle", done, 0);
    chk(!busy && !rd_valid && !wr_valid, "R2", "idle after transfer", {busy, rd_valid, wr_valid}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_valid && !wr_valid && qw_left == '0, "R1", "reset state",
        {busy, done, rd_valid, wr_valid, qw_left}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rd_valid && !wr_valid, "R2", "idle without start", {busy, rd_valid, wr_valid}, 0);

    run_xfer(0, 8, 32'h1000, 32'h8000, 2, 3, 0, -1);
    run_xfer(1, 8, 32'h2000, 32'h9000, 3, 1, 0, -1);
    run_xfer(0, 9, 32'h3000, 32'h0100, 0, 5, 1, -1);
    run_xfer(1, 5, 32'h4000, 32'h0200, 7, 4, 1, -1);
    run_xfer(0, 1, 32'h5000, 32'h0300, 1, 2, 1, -1);
    run_xfer(1, 6, 32'h6000, 32'h0400, 1, 1, 1, -1);
    run_xfer(0, 0, 32'h7000, 32'h0500, 2, 2, 0, -1);
    run_xfer(1, 0, 32'h7000, 32'h0500, 0, 0, 1, -1);
    run_xfer(0, 10, 32'h8000, 32'h0600, 4, 2, 1, 3);
    run_xfer(1, 12, 32'h9000, 32'h0700, 5, 0, 0, 2);

    for (int i = 0; i < 30; i++) begin
      run_xfer($urandom % 2, $urandom % 40, {16'h0, 12'($urandom), 4'h0},
               {16'h1, 12'($urandom), 4'h0}, $urandom % 9, $urandom % 6,
               $urandom % 4 != 0, (i % 5 == 0) ? 4 : -1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule